// File: doc/BRIEF.md
# Serial Word RAM Slave with Shadow Copy

This block is a slave on a three-wire serial bus: a chip select, a serial clock and a data input, plus a data output with its own output enable for a shared or tri-stated line. Behind the bus sits an array of 2^ADDR_W words of DATA_W bits (16 x 16 by default), and next to it a shadow array of the same size that stands in for non-volatile cells. The host selects the block and clocks in an 8-bit command: a start bit, an address and an opcode. The command then either moves one word in or out, or changes the block's mode.

The bus pins are sampled on a fast system clock, and edges of the serial clock are detected from the samples. The serial clock can therefore stop at any level for any length of time. A read word starts on the bus at the falling edge of the eighth serial clock. The last command bit of a read is ignored, so the host can turn a shared data line around without contention. Whole-array copies between the working array and the shadow array can be started by command or by two dedicated pins.

Top module: `sram_ser_top`

## Requirements
- R1: After reset the output enable is low, every word of both arrays is zero, the write-enable latch is clear and the sleep flag is clear.
- R2: While chip select is high, data input bits are sampled on serial-clock rising edges. Zeros before the first 1 (the start bit) are skipped. After the start bit come the address, most significant bit first, and then the opcode, most significant bit first.
- R3: Opcode 110 reads the addressed word, and the eighth command bit is ignored. The output enable stays low after rising edge 8. It goes high at falling edge 8, with bit 15 on the data output. Bits 14 down to 0 follow rising edges 9 to 23. The enable drops at rising edge 24.
- R4: The sample after chip select goes low always has the output enable low.
- R5: Opcode 011 with the latch set receives data bits most significant first. The word is written when chip select falls, and only if exactly 16 data bits arrived. With fewer or more bits the word keeps its value.
- R6: Opcode 100 sets the write-enable latch and opcode 000 clears it. While the latch is clear, write and store commands have no effect.
- R7: If chip select falls before the eighth command bit, the command is dropped and the shifter is emptied. The next selection decodes a fresh command.
- R8: Opcode 001 copies the whole working array into the shadow array. Opcode 101 copies the shadow array back and is not gated by the latch.
- R9: A rising edge on the store pin or on the recall pin performs the same copy as the command, whatever the state of the latch.
- R10: Opcode 010 sets the sleep flag. While it is set, reads never drive the output and writes are ignored. A recall, by command or by pin, clears the flag.
- R11: The serial clock may pause at any level inside a transfer without changing the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus pins |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_cs | input | 1 | Chip select, high for the whole transfer |
| ser_clk | input | 1 | Serial clock, edges detected on clk |
| ser_din | input | 1 | Serial data input |
| ser_dout | output | 1 | Serial data output, low while not enabled |
| ser_dout_en | output | 1 | Drive enable for the data output |
| store_pin | input | 1 | Rising edge copies the working array to the shadow array |
| recall_pin | input | 1 | Rising edge copies the shadow array to the working array |

## Verification
The bench uses the default widths, ADDR_W = 4 and DATA_W = 16. The 24-clock read frame and the 16-bit write boundary are then short enough to hit exactly, together with the 15-bit and 17-bit misses on either side. Address 15, whose bits are all ones, and address 0 are both reachable, so the decoding of every address bit is exercised. The whole-array copies are also small enough to observe word by word through ordinary reads.

// File: rtl/sram_ser_pkg.sv
package sram_ser_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_INSTR, ST_RWAIT, ST_RDATA, ST_WDATA, ST_DONE
  } ser_state_t;

  localparam logic [2:0] OP_READ   = 3'b110;
  localparam logic [2:0] OP_WRITE  = 3'b011;
  localparam logic [2:0] OP_RECALL = 3'b101;
  localparam logic [2:0] OP_WEN    = 3'b100;
  localparam logic [2:0] OP_WDIS   = 3'b000;
  localparam logic [2:0] OP_STORE  = 3'b001;
  localparam logic [2:0] OP_SLEEP  = 3'b010;

  // Only the read opcode starts with 11, so a read is known after two opcode bits.
  function automatic logic is_read_prefix(input logic [1:0] hi);
    return hi == OP_READ[2:1];
  endfunction

  function automatic logic [2:0] full_opcode(input logic [1:0] hi, input logic lo);
    return {hi, lo};
  endfunction

endpackage

// File: rtl/sram_ser_sampler.sv
module sram_ser_sampler #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] prev
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) prev[i] <= 1'b0;
      else        prev[i] <= lvl[i];
    end
  end
endmodule

// File: rtl/sram_ser_store.sv
module sram_ser_store #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [DATA_W-1:0]         wr_data,
  input  logic                      do_store,
  input  logic                      do_recall,
  input  logic [ADDR_W-1:0]         rd_addr,
  output logic [DATA_W-1:0]         rd_word,
  output logic [DEPTH*DATA_W-1:0]   mem_flat,
  output logic [DEPTH*DATA_W-1:0]   shadow_flat
);
  logic [DATA_W-1:0] ram    [DEPTH];
  logic [DATA_W-1:0] shadow [DEPTH];

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ram[w]    <= '0;
        shadow[w] <= '0;
      end else begin
        // recall outranks a same-cycle write commit
        if (do_recall)                                   ram[w] <= shadow[w];
        else if (wr_en && wr_addr == ADDR_W'(w))         ram[w] <= wr_data;
        if (do_store)                                    shadow[w] <= ram[w];
      end
    end
    assign mem_flat[w*DATA_W +: DATA_W]    = ram[w];
    assign shadow_flat[w*DATA_W +: DATA_W] = shadow[w];
  end

  assign rd_word = ram[rd_addr];
endmodule

// File: rtl/sram_ser_ctrl.sv
module sram_ser_ctrl
  import sram_ser_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  localparam int INS_W = 1 + ADDR_W + 3,
  localparam int BC_W  = $clog2(INS_W),
  localparam int DC_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_cs,
  input  logic              ser_din,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              cs_fall,
  input  logic              recall_any,
  input  logic [DATA_W-1:0] rd_word,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              ev_commit,
  output logic              store_cmd,
  output logic              recall_cmd,
  output logic              cmd_exec,
  output logic              dout,
  output logic              dout_en,
  output logic              wen,
  output logic              sleeping
);
  ser_state_t        state;
  logic [ADDR_W+1:0] ins_sh;
  logic [BC_W-1:0]   bcnt;
  logic [DC_W-1:0]   dcnt;
  logic [DATA_W-1:0] rd_sh;
  logic [2:0]        op_now;

  assign rd_addr    = ins_sh[ADDR_W+1:2];
  assign op_now     = full_opcode(ins_sh[1:0], ser_din);
  assign cmd_exec   = ser_cs && sclk_rise && state == ST_INSTR && bcnt == BC_W'(INS_W - 1);
  assign store_cmd  = cmd_exec && op_now == OP_STORE && wen;
  assign recall_cmd = cmd_exec && op_now == OP_RECALL;
  assign ev_commit  = cs_fall && state == ST_WDATA && dcnt == DC_W'(DATA_W);
  assign dout       = dout_en & rd_sh[DATA_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      ins_sh   <= '0;
      bcnt     <= '0;
      dcnt     <= '0;
      rd_sh    <= '0;
      wr_data  <= '0;
      wr_addr  <= '0;
      dout_en  <= 1'b0;
      wen      <= 1'b0;
      sleeping <= 1'b0;
    end else begin
      if (!ser_cs) begin
        state   <= ST_IDLE;
        ins_sh  <= '0;
        bcnt    <= '0;
        dcnt    <= '0;
        dout_en <= 1'b0;
      end else begin
        unique case (state)
          ST_IDLE: if (sclk_rise && ser_din) begin
            ins_sh <= '0;
            bcnt   <= BC_W'(1);
            state  <= ST_INSTR;
          end
          ST_INSTR: if (sclk_rise) begin
            if (bcnt == BC_W'(INS_W - 1)) begin
              wr_addr <= rd_addr;
              dcnt    <= '0;
              state   <= ST_DONE;
              if (is_read_prefix(ins_sh[1:0])) begin
                if (!sleeping) begin
                  rd_sh <= rd_word;
                  state <= ST_RWAIT;
                end
              end else begin
                unique case (op_now)
                  OP_WRITE: if (wen && !sleeping) state <= ST_WDATA;
                  OP_WEN:   wen <= 1'b1;
                  OP_WDIS:  wen <= 1'b0;
                  OP_SLEEP: sleeping <= 1'b1;
                  default:  ;
                endcase
              end
            end else begin
              ins_sh <= {ins_sh[ADDR_W:0], ser_din};
              bcnt   <= bcnt + BC_W'(1);
            end
          end
          ST_RWAIT: if (sclk_fall) begin
            dout_en <= 1'b1;
            dcnt    <= DC_W'(1);
            state   <= ST_RDATA;
          end
          ST_RDATA: if (sclk_rise) begin
            if (dcnt == DC_W'(DATA_W)) begin
              dout_en <= 1'b0;
              state   <= ST_DONE;
            end else begin
              rd_sh <= {rd_sh[DATA_W-2:0], 1'b0};
              dcnt  <= dcnt + DC_W'(1);
            end
          end
          ST_WDATA: if (sclk_rise) begin
            if (dcnt == DC_W'(DATA_W)) state <= ST_DONE;
            else begin
              wr_data <= {wr_data[DATA_W-2:0], ser_din};
              dcnt    <= dcnt + DC_W'(1);
            end
          end
          default: ;
        endcase
      end
      if (recall_any) sleeping <= 1'b0;
    end
  end
endmodule

// File: rtl/sram_ser_top.sv
module sram_ser_top #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_cs,
  input  logic ser_clk,
  input  logic ser_din,
  output logic ser_dout,
  output logic ser_dout_en,
  input  logic store_pin,
  input  logic recall_pin
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int FLAT_W = DEPTH * DATA_W;

  logic [3:0] pins_now, pins_prev;
  logic sclk_rise, sclk_fall, cs_fall, store_rise, recall_rise;
  logic ev_commit, ev_store, ev_recall, store_cmd, recall_cmd, cmd_exec;
  logic wen, sleeping;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [DATA_W-1:0] rd_word, wr_data;
  logic [FLAT_W-1:0] mem_flat, shadow_flat;

  assign pins_now = {recall_pin, store_pin, ser_cs, ser_clk};

  sram_ser_sampler #(.N(4)) u_samp (
    .clk(clk), .rst_n(rst_n), .lvl(pins_now), .prev(pins_prev)
  );

  assign sclk_rise   =  pins_now[0] & ~pins_prev[0];
  assign sclk_fall   = ~pins_now[0] &  pins_prev[0];
  assign cs_fall     = ~pins_now[1] &  pins_prev[1];
  assign store_rise  =  pins_now[2] & ~pins_prev[2];
  assign recall_rise =  pins_now[3] & ~pins_prev[3];
  assign ev_store    = store_cmd | store_rise;
  assign ev_recall   = recall_cmd | recall_rise;

  sram_ser_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ser_cs(ser_cs), .ser_din(ser_din),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .cs_fall(cs_fall),
    .recall_any(ev_recall), .rd_word(rd_word), .rd_addr(rd_addr),
    .wr_addr(wr_addr), .wr_data(wr_data), .ev_commit(ev_commit),
    .store_cmd(store_cmd), .recall_cmd(recall_cmd), .cmd_exec(cmd_exec),
    .dout(ser_dout), .dout_en(ser_dout_en), .wen(wen), .sleeping(sleeping)
  );

  sram_ser_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(ev_commit), .wr_addr(wr_addr),
    .wr_data(wr_data), .do_store(ev_store), .do_recall(ev_recall),
    .rd_addr(rd_addr), .rd_word(rd_word), .mem_flat(mem_flat),
    .shadow_flat(shadow_flat)
  );
endmodule

// File: rtl/sram_ser_checker.sv
module sram_ser_checker #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  localparam int FLAT_W = (1 << ADDR_W) * DATA_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ser_cs,
  input logic              ser_dout_en,
  input logic              sclk_fall,
  input logic              ev_commit,
  input logic              ev_store,
  input logic              ev_recall,
  input logic              wen,
  input logic              sleeping,
  input logic [FLAT_W-1:0] mem_flat,
  input logic [FLAT_W-1:0] shadow_flat
);
  AST_OE_OFF_WITHOUT_CS: assert property (@(posedge clk) disable iff (!rst_n) !ser_cs |=> !ser_dout_en); // R4
  AST_OE_STARTS_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n) $rose(ser_dout_en) |-> $past(sclk_fall)); // R3
  AST_COMMIT_NEEDS_LATCH: assert property (@(posedge clk) disable iff (!rst_n) ev_commit |-> (wen && !sleeping)); // R6
  AST_RAM_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (!ev_commit && !ev_recall) |=> $stable(mem_flat)); // R5
  AST_SHADOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) !ev_store |=> $stable(shadow_flat)); // R8
  AST_STORE_COPIES: assert property (@(posedge clk) disable iff (!rst_n) (ev_store && !ev_recall) |=> shadow_flat == $past(mem_flat)); // R8
  AST_RECALL_COPIES: assert property (@(posedge clk) disable iff (!rst_n) (ev_recall && !ev_store) |=> mem_flat == $past(shadow_flat)); // R9
endmodule

bind sram_ser_top sram_ser_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ser_cs(ser_cs), .ser_dout_en(ser_dout_en),
  .sclk_fall(sclk_fall), .ev_commit(ev_commit), .ev_store(ev_store),
  .ev_recall(ev_recall), .wen(wen), .sleeping(sleeping),
  .mem_flat(mem_flat), .shadow_flat(shadow_flat)
);

// File: tb/sram_ser_top_test.sv
module sram_ser_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_cs = 1'b0, ser_clk = 1'b0, ser_din = 1'b0;
  logic store_pin = 1'b0, recall_pin = 1'b0;
  logic ser_dout, ser_dout_en;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  sram_ser_top uut (
    .clk(clk), .rst_n(rst_n), .ser_cs(ser_cs), .ser_clk(ser_clk),
    .ser_din(ser_din), .ser_dout(ser_dout), .ser_dout_en(ser_dout_en),
    .store_pin(store_pin), .recall_pin(recall_pin)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic begin_xfer();
    @(negedge clk) ser_cs = 1'b1;
    idle(2);
  endtask

  task automatic end_xfer();
    @(negedge clk) begin ser_cs = 1'b0; ser_din = 1'b0; end
    idle(4);
  endtask

  task automatic send(input logic b, input int hold = 0);
    @(negedge clk) ser_din = b;
    idle(2);
    ser_clk = 1'b1;
    idle(HALF + hold);
    ser_clk = 1'b0;
    idle(HALF);
  endtask

  task automatic cmd(input logic [2:0] op);
    begin_xfer();
    send(1'b1);
    send(1'b1); send(1'b0); send(1'b1); send(1'b0);
    for (int i = 2; i >= 0; i--) send(op[i]);
    end_xfer();
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d, input int nbits = 16, input bit pause = 1'b0);
    begin_xfer();
    send(1'b1);
    for (int i = 3; i >= 0; i--) send(a[i]);
    send(1'b0); send(1'b1); send(1'b1);
    for (int i = 0; i < nbits; i++)
      send((i < 16) ? d[15-i] : 1'b0, (pause && i == 7) ? 300 : 0);
    end_xfer();
  endtask

  task automatic rd(input logic [3:0] a, input logic [15:0] exp, input bit drive, input string req, input int lead = 0);
    logic [15:0] got;
    bit all_on, any_on, early, late;
    got = '0; all_on = 1'b1; any_on = 1'b0;
    begin_xfer();
    for (int i = 0; i < lead; i++) send(1'b0);
    send(1'b1);
    for (int i = 3; i >= 0; i--) send(a[i]);
    send(1'b1); send(1'b1);
    @(negedge clk) ser_din = 1'b1;      // ignored eighth bit
    idle(2);
    ser_clk = 1'b1;
    idle(HALF);
    early = ser_dout_en;
    ser_clk = 1'b0;
    idle(HALF);
    got[15] = ser_dout; all_on &= ser_dout_en; any_on |= ser_dout_en;
    for (int i = 14; i >= 0; i--) begin
      ser_clk = 1'b1;
      idle(HALF);
      got[i] = ser_dout; all_on &= ser_dout_en; any_on |= ser_dout_en;
      ser_clk = 1'b0;
      idle(HALF);
    end
    ser_clk = 1'b1;
    idle(HALF);
    late = ser_dout_en;
    ser_clk = 1'b0;
    idle(HALF);
    end_xfer();
    if (drive) begin
      check(!early, "R3 enable low after rising edge 8", 16'(early), 16'h0);
      check(all_on, "R3 enable high over bits 15..0", 16'(all_on), 16'h1);
      check(got == exp, req, got, exp);
      check(!late, "R3 enable low after rising edge 24", 16'(late), 16'h0);
    end else begin
      check(!any_on && !early, req, 16'(any_on), 16'h0);
    end
  endtask

  task automatic t_reset();
    check(ser_dout_en == 1'b0, "R1 enable low after reset", 16'(ser_dout_en), 16'h0);
    rd(4'h0, 16'h0000, 1'b1, "R1 word 0 zero after reset");
    rd(4'hF, 16'h0000, 1'b1, "R1 word 15 zero after reset");
    wr(4'h4, 16'hBEEF);
    rd(4'h4, 16'h0000, 1'b1, "R1 R6 latch clear after reset blocks write");
  endtask

  task automatic t_write_read();
    cmd(3'b100);
    wr(4'h5, 16'hA5C3);
    wr(4'hF, 16'h8001);
    wr(4'h0, 16'hFFFF);
    rd(4'h5, 16'hA5C3, 1'b1, "R2 R5 word 5 written");
    rd(4'hF, 16'h8001, 1'b1, "R2 R5 word 15 written");
    rd(4'h0, 16'hFFFF, 1'b1, "R2 R5 word 0 written");
    rd(4'hF, 16'h8001, 1'b1, "R2 leading zeros skipped", 3);
  endtask

  task automatic t_partial();
    wr(4'h5, 16'h1234, 15);
    rd(4'h5, 16'hA5C3, 1'b1, "R5 15-bit write discarded");
    wr(4'h5, 16'h1234, 17);
    rd(4'h5, 16'hA5C3, 1'b1, "R5 17-bit write discarded");
  endtask

  task automatic t_abort();
    cmd(3'b000);
    wr(4'h5, 16'h1111);
    rd(4'h5, 16'hA5C3, 1'b1, "R6 write ignored after disable");
    begin_xfer();                        // enable command cut before bit 8
    send(1'b1); send(1'b1); send(1'b0); send(1'b1); send(1'b0); send(1'b1); send(1'b0);
    end_xfer();
    wr(4'h5, 16'h2468);
    rd(4'h5, 16'hA5C3, 1'b1, "R7 cut enable command not executed");
    begin_xfer();                        // stray ones, then drop select
    send(1'b1); send(1'b1); send(1'b1);
    end_xfer();
    rd(4'hF, 16'h8001, 1'b1, "R7 shifter cleared for next command");
    begin_xfer();                        // drop select in the middle of read data
    send(1'b1); send(1'b0); send(1'b1); send(1'b0); send(1'b1); send(1'b1); send(1'b1); send(1'b0);
    send(1'b0); send(1'b0);
    check(ser_dout_en == 1'b1, "R4 enable high mid-read", 16'(ser_dout_en), 16'h1);
    @(negedge clk) ser_cs = 1'b0;
    idle(2);
    check(ser_dout_en == 1'b0, "R4 enable low once select drops", 16'(ser_dout_en), 16'h0);
    idle(2);
  endtask

  task automatic t_store_recall();
    cmd(3'b100);
    cmd(3'b001);
    wr(4'h5, 16'h0000);
    rd(4'h5, 16'h0000, 1'b1, "R5 overwrite before recall");
    cmd(3'b101);
    rd(4'h5, 16'hA5C3, 1'b1, "R8 recall restores stored word");
    rd(4'h0, 16'hFFFF, 1'b1, "R8 recall restores word 0");
    wr(4'h5, 16'h7777);
    cmd(3'b000);
    cmd(3'b001);
    cmd(3'b101);
    rd(4'h5, 16'hA5C3, 1'b1, "R6 store ignored with latch clear");
  endtask

  task automatic pulse(input bit is_store);
    @(negedge clk) if (is_store) store_pin = 1'b1; else recall_pin = 1'b1;
    idle(2);
    store_pin = 1'b0; recall_pin = 1'b0;
    idle(2);
  endtask

  task automatic t_pins();
    cmd(3'b100);
    wr(4'h5, 16'h2222);
    cmd(3'b000);
    pulse(1'b1);
    cmd(3'b100);
    wr(4'h5, 16'h3333);
    cmd(3'b000);
    pulse(1'b0);
    rd(4'h5, 16'h2222, 1'b1, "R9 pins copy regardless of latch");
  endtask

  task automatic t_sleep();
    cmd(3'b100);
    cmd(3'b010);
    rd(4'h5, 16'h2222, 1'b0, "R10 sleeping read never drives");
    wr(4'h5, 16'h4444);
    pulse(1'b1);
    cmd(3'b101);
    rd(4'h5, 16'h2222, 1'b1, "R10 sleeping write ignored, recall wakes");
  endtask

  task automatic t_pause();
    wr(4'h7, 16'hC0DE, 16, 1'b1);
    rd(4'h7, 16'hC0DE, 1'b1, "R11 paused serial clock");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    summary();
  end

  initial begin
    idle(5);
    rst_n = 1'b1;
    idle(3);
    t_reset();
    t_write_read();
    t_partial();
    t_abort();
    t_store_recall();
    t_pins();
    t_sleep();
    t_pause();
    idle(5);
    summary();
  end
endmodule